// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Set-on-Less-Than

This block is a 32-bit integer arithmetic and logic unit assembled from a row of identical one-bit slices. Each slice forms the AND, the OR and the full-adder sum of its operand bits, and a small multiplexer inside the slice picks one of them, or a fourth "less" input, under the low two bits of a three-bit operation code. The carry ripples from slice to slice. The top bit of the operation code inverts every b bit and also supplies the carry into bit 0, so the same chain adds or subtracts.

Set-on-less-than does not use a separate comparator. The top slice's sum bit is XORed with the signed-overflow condition to give the true sign of a − b. That bit is fed back as the less input of slice 0, and every other slice's less input is held at zero. A zero flag (the NOR of the result), a signed overflow flag and the final carry-out come with the result. Operand b is taken either from a register value or from a 16-bit immediate that is sign-extended. The combinational result and flags are captured in output registers, so each operation appears one clock after it is presented.

Top module: `rip_alu`

## Requirements
- R1: Code 000 gives a AND b on the result.
- R2: Code 001 gives a OR b on the result.
- R3: Code 010 gives a + b modulo 2^32, with the carry out of bit 31 on the carry output.
- R4: Code 110 gives a − b modulo 2^32, with the carry output at 1 exactly when a ≥ b as unsigned numbers (no borrow).
- R5: Code 111 gives 1 when a < b as signed numbers and 0 otherwise, including operand pairs whose difference overflows; result bits 31..1 are always 0.
- R6: The overflow output is 1 only for codes 010 and 110, and then exactly when the signed sum or difference falls outside [−2^31, 2^31−1]. An add with operands of opposite sign, or a subtract with operands of the same sign, never flags it.
- R7: The zero output is 1 exactly when all 32 result bits are 0.
- R8: With the immediate select at 1, operand b is the 16-bit immediate sign-extended (bit 15 copied into bits 31..16). With the select at 0, operand b is the register operand.
- R9: Bit 2 of the code inverts b and forces the carry into bit 0. Code 100 gives a AND NOT b. Code 101 gives a OR NOT b. Code 011 gives 1 exactly when the true signed sum a + b is negative.
- R10: Result and flags appear one clock after the inputs. While reset is high, the outputs are result 0, zero 1, overflow 0 and carry 0.
- R11: The carry output is 0 for codes whose bit 1 is 0 (the logic codes). For codes whose bit 1 is 1, it is the carry out of bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand a |
| rb_i | input | 32 | Register value for operand b |
| imm_i | input | 16 | Immediate for operand b |
| use_imm_i | input | 1 | 1 selects the sign-extended immediate as b |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered result-is-zero flag |
| ovf_o | output | 1 | Registered signed overflow flag |
| cout_o | output | 1 | Registered carry out of bit 31 |

## Verification
The assertions assume that op_i, a_i, rb_i, imm_i and use_imm_i are known, two-state values on every rising edge outside reset. They also assume that reset is held for at least one edge before any property is relied on. The stimulus meets both conditions. Reset is raised from time zero, and every input is driven to a defined value on the falling edge, half a period before the edge that captures it. All eight operation codes are driven, including the three unnamed ones, so the properties that depend on the code never see an unassigned value.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_SLTA = 3'b011,
    OP_ANDN = 3'b100,
    OP_ORN  = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  // Low two code bits: slice output select
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;
endpackage

// File: rtl/alu_bsel.sv
module alu_bsel #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [W-1:0]     b_o
);
  localparam int EXT_W = W - IMM_W;
  logic [W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_noext
      assign imm_ext = imm_i[W-1:0];
    end
  endgenerate

  assign b_o = use_imm_i ? imm_ext : reg_i;
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       sum_o,
  output logic       cout_o,
  output logic       res_o
);
  logic bx;

  assign bx     = b_i ^ binv_i;
  assign sum_o  = a_i ^ bx ^ cin_i;
  assign cout_o = (a_i & bx) | (a_i & cin_i) | (bx & cin_i);

  always_comb begin
    case (slice_sel_e'(sel_i))
      SEL_AND:  res_o = a_i & bx;
      SEL_OR:   res_o = a_i | bx;
      SEL_SUM:  res_o = sum_o;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags (
  input  logic cin_msb_i,
  input  logic cout_msb_i,
  input  logic sum_msb_i,
  output logic ovf_o,
  output logic set_o
);
  // Signed overflow: carry into sign bit differs from carry out of it
  assign ovf_o = cin_msb_i ^ cout_msb_i;
  // Corrected sign of the true result
  assign set_o = sum_msb_i ^ ovf_o;
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  assign zero_o = ~(|val_i);
endmodule

// File: rtl/rip_alu.sv
module rip_alu
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     rb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [W-1:0]     res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   carry;
  logic [W-1:0] sum_v;
  logic [W-1:0] res_v;
  logic         binv;
  logic [1:0]   sel;
  logic         ovf_raw;
  logic         set_bit;
  logic         zero_v;
  logic         arith;

  assign binv     = op_i[2];
  assign sel      = op_i[1:0];
  assign carry[0] = binv;
  assign arith    = (slice_sel_e'(sel) == SEL_SUM);

  alu_bsel #(.W(W), .IMM_W(IMM_W)) u_bsel (
    .reg_i     (rb_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .b_o       (b_eff)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      logic less_in;
      if (i == 0) begin : g_lsb
        assign less_in = set_bit;
      end else begin : g_rest
        assign less_in = 1'b0;
      end
      alu_bit_slice u_slice (
        .a_i    (a_i[i]),
        .b_i    (b_eff[i]),
        .binv_i (binv),
        .cin_i  (carry[i]),
        .less_i (less_in),
        .sel_i  (sel),
        .sum_o  (sum_v[i]),
        .cout_o (carry[i+1]),
        .res_o  (res_v[i])
      );
    end
  endgenerate

  alu_msb_flags u_msb (
    .cin_msb_i  (carry[MSB]),
    .cout_msb_i (carry[W]),
    .sum_msb_i  (sum_v[MSB]),
    .ovf_o      (ovf_raw),
    .set_o      (set_bit)
  );

  alu_zero_det #(.W(W)) u_zero (
    .val_i  (res_v),
    .zero_o (zero_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b1;
      ovf_o  <= 1'b0;
      cout_o <= 1'b0;
    end else begin
      res_o  <= res_v;
      zero_o <= zero_v;
      ovf_o  <= arith & ovf_raw;
      cout_o <= op_i[1] & carry[W];
    end
  end
endmodule

// File: rtl/rip_alu_chk.sv
module rip_alu_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_i,
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     rb_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic [W-1:0]     res_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             cout_o
);
  logic [W-1:0] b_chk;
  logic         b_sign;
  assign b_chk  = use_imm_i ? W'($signed(imm_i)) : rb_i;
  assign b_sign = b_chk[W-1];

  // R10: outputs after a reset edge
  a_r10_reset_vals: assert property (@(posedge clk)
    rst |=> (res_o == '0 && zero_o && !ovf_o && !cout_o));

  // R7: zero flag follows result
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  // R6: no overflow outside add/sub codes
  a_r6_no_ovf_logic: assert property (@(posedge clk) disable iff (rst)
    (op_i[1:0] != 2'b10) |=> !ovf_o);

  // R6: mixed-sign add cannot overflow
  a_r6_add_mixed: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b010 && a_i[W-1] != b_sign) |=> !ovf_o);

  // R6: same-sign subtract cannot overflow
  a_r6_sub_same: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b110 && a_i[W-1] == b_sign) |=> !ovf_o);

  // R5: set-on-less-than upper bits are zero
  a_r5_slt_upper: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b111) |=> (res_o[W-1:1] == '0));

  // R11: no carry reported for logic codes
  a_r11_cout_logic: assert property (@(posedge clk) disable iff (rst)
    (op_i[1] == 1'b0) |=> !cout_o);

  // R3: add result one cycle later
  a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b010) |=> (res_o == $past(a_i + b_chk)));
endmodule

bind rip_alu rip_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/sim_rip_alu.sv
module sim_rip_alu;
  localparam int W = 32;
  localparam int IMM_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       op_i = '0;
  logic [W-1:0]     a_i = '0;
  logic [W-1:0]     rb_i = '0;
  logic [IMM_W-1:0] imm_i = '0;
  logic             use_imm_i = 1'b0;
  logic [W-1:0]     res_o;
  logic             zero_o, ovf_o, cout_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rip_alu #(.W(W), .IMM_W(IMM_W)) u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .rb_i(rb_i),
    .imm_i(imm_i), .use_imm_i(use_imm_i), .res_o(res_o),
    .zero_o(zero_o), .ovf_o(ovf_o), .cout_o(cout_o)
  );

  function automatic string tag_of(input logic [2:0] op, input bit imm);
    string t;
    case (op)
      3'b000: t = "R1";
      3'b001: t = "R2";
      3'b010: t = "R3";
      3'b110: t = "R4";
      3'b111: t = "R5";
      default: t = "R9";
    endcase
    if (imm) t = {t, "/R8"};
    return t;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference, one operation per call
  task automatic run_op(input logic [2:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] rb, input logic [IMM_W-1:0] imm,
                        input bit use_imm);
    logic [W-1:0] b, bv, er;
    logic [W:0]   s;
    longint sa, sb, tv;
    bit eo, ec;
    string t;
    b  = use_imm ? {{(W-IMM_W){imm[IMM_W-1]}}, imm} : rb;
    bv = op[2] ? ~b : b;
    s  = {1'b0, a} + {1'b0, bv} + {{W{1'b0}}, op[2]};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    tv = op[2] ? (sa - sb) : (sa + sb);
    case (op[1:0])
      2'b00: er = a & bv;
      2'b01: er = a | bv;
      2'b10: er = s[W-1:0];
      default: er = (tv < 0) ? 1 : 0;
    endcase
    eo = (op[1:0] == 2'b10) && (tv > 64'sd2147483647 || tv < -64'sd2147483648);
    ec = op[1] ? s[W] : 1'b0;
    @(negedge clk);
    op_i = op; a_i = a; rb_i = rb; imm_i = imm; use_imm_i = use_imm;
    @(negedge clk);
    t = tag_of(op, use_imm);
    check(t, "result", res_o, er);
    check("R7", "zero", W'(zero_o), W'(er == '0));
    check("R6", "overflow", W'(ovf_o), W'(eo));
    check(op[1] ? t : "R11", "carry", W'(cout_o), W'(ec));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset result", res_o, '0);
    check("R10", "reset zero", W'(zero_o), 1);
    check("R10", "reset ovf/cout", W'({ovf_o, cout_o}), 0);
    rst = 1'b0;

    // Directed corners
    run_op(3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF, '0, 0);   // R1
    run_op(3'b001, 32'hF000_0001, 32'h0000_1230, '0, 0);   // R2
    run_op(3'b010, 32'h7FFF_FFFF, 32'h0000_0001, '0, 0);   // R3 overflow R6
    run_op(3'b010, 32'hFFFF_FFFF, 32'h0000_0001, '0, 0);   // R3 carry, zero R7
    run_op(3'b010, 32'h8000_0000, 32'h8000_0000, '0, 0);   // R6 negative overflow
    run_op(3'b010, 32'h7FFF_FFFF, 32'h8000_0000, '0, 0);   // R6 mixed signs
    run_op(3'b110, 32'h0000_0005, 32'h0000_0005, '0, 0);   // R4 equal, R7
    run_op(3'b110, 32'h0000_0003, 32'h0000_0007, '0, 0);   // R4 borrow
    run_op(3'b110, 32'h8000_0000, 32'h0000_0001, '0, 0);   // R6 sub overflow
    run_op(3'b110, 32'h7FFF_FFFF, 32'h7FFF_0000, '0, 0);   // R6 same sign sub
    run_op(3'b111, 32'h8000_0000, 32'h0000_0001, '0, 0);   // R5 overflowing diff
    run_op(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, '0, 0);   // R5 overflowing diff
    run_op(3'b111, 32'hFFFF_FFFF, 32'h0000_0000, '0, 0);   // R5 -1 < 0
    run_op(3'b111, 32'h0000_0004, 32'h0000_0004, '0, 0);   // R5 equal
    run_op(3'b100, 32'hFFFF_00FF, 32'h0F0F_0F0F, '0, 0);   // R9
    run_op(3'b101, 32'h0000_0000, 32'hFFFF_0000, '0, 0);   // R9
    run_op(3'b011, 32'h8000_0000, 32'hFFFF_FFFF, '0, 0);   // R9
    run_op(3'b010, 32'h0000_0010, 32'hDEAD_BEEF, 16'hFFFF, 1); // R8 negative imm
    run_op(3'b010, 32'h0000_0010, 32'hDEAD_BEEF, 16'h7FFF, 1); // R8 positive imm
    run_op(3'b111, 32'hFFFF_8000, 32'h0000_0000, 16'h8000, 1); // R8 equal via imm

    // Random sweep across all codes
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] ra, rbv;
      logic [31:0] r3;
      ra  = $urandom;
      rbv = $urandom;
      r3  = $urandom;
      if (r3[3]) ra = {ra[31], {31{ra[30]}}};
      run_op(r3[2:0], ra, rbv, rbv[31:16], r3[4]);
    end

    // R10: reset returns outputs to idle values
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10", "re-reset result", res_o, '0);
    check("R10", "re-reset flags", W'({zero_o, ovf_o, cout_o}), W'(3'b100));

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule